// File: doc/BRIEF.md
# Serial Device-Address CRC Checker

This block takes in a 64-bit 1-Wire device address that arrives one bit per strobe. The least significant bit of the address comes first. The address holds three fields. The low byte is a family code. Above it is a 48-bit serial number. The most significant byte is a CRC-8 check value. The block runs the CRC over the first 56 bits and stores the family and serial fields. It then compares the final byte it receives with the CRC it computed. A host or a bus-side sequencer feeds it the bits that come out of a ROM read. The result tells it whether the address arrived intact and whether the device belongs to the expected family.

A failed check only produces a status indication. The frame still completes and the fields are still captured, so the surrounding logic decides what to do next. A start pulse clears the current frame at any point and readies the block for a new address.

Top module: `addr_crc_check`

## Requirements
- R1: After reset, done_o, match_o and family_ok_o are low, and crc_o, family_o and serial_o are all zero.
- R2: The CRC uses the polynomial x^8+x^5+x^4+1 in shift-right form. The register starts at zero. For each bit, the feedback is the input bit XOR the register LSB; the register shifts right and, when the feedback is 1, is XORed with 0x8C. crc_o shows the updated value one cycle after each of the first 56 accepted bits, and accepted bits 57 to 64 leave it unchanged.
- R3: The first accepted bit is bit 0 of the address. In the cycle after the 64th accepted bit, family_o holds address bits 7:0 and serial_o holds address bits 55:8.
- R4: done_o is high for exactly one cycle, the cycle after the 64th accepted bit.
- R5: match_o is set together with done_o when address bits 63:56 equal the computed CRC, and is cleared otherwise. A mismatch still raises done_o and still captures the fields.
- R6: family_ok_o is set together with done_o when the captured family code equals 0x31, and is cleared otherwise.
- R7: Cycles with bit_valid_i low are ignored. Gaps between bits do not change the result.
- R8: start_i resets the bit count and the CRC to zero and clears match_o and family_ok_o. A bit presented in the same cycle as start_i is not accepted.
- R9: Once 64 bits have been accepted, further bits are ignored until the next start_i. done_o does not pulse again, and crc_o, family_o, serial_o and match_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Abort the current frame and begin a new one |
| bit_valid_i | input | 1 | bit_data_i carries an address bit this cycle |
| bit_data_i | input | 1 | Serial address bit, LSB first |
| crc_o | output | 8 | Running or final computed CRC |
| family_o | output | 8 | Captured family code |
| serial_o | output | 48 | Captured serial number |
| done_o | output | 1 | One-cycle pulse after the 64th bit |
| match_o | output | 1 | Received CRC byte equals computed CRC |
| family_ok_o | output | 1 | Captured family code equals 0x31 |

## Verification
Each accepted bit passes through one register. The running CRC therefore changes one cycle after its bit, and done, match, family_ok and the captured fields all change one cycle after the 64th accepted bit. The bench drives every input on the falling clock edge and reads the outputs at the following falling edge. It reads crc_o just before the 57th bit is driven, and it reads done and the fields right after the final bit. It then checks, one cycle later, that done has dropped. Start pulses and bits that arrive after the frame is full are each followed by a read of the same outputs before any further stimulus.

// File: rtl/aocrc_pkg.sv
package aocrc_pkg;

    // Which part of the address frame the next accepted bit belongs to
    typedef enum logic [1:0] {
        PH_DATA = 2'd0,   // family or serial bit, fed to the CRC
        PH_TAIL = 2'd1,   // received CRC byte
        PH_FULL = 2'd2    // frame complete, bits ignored
    } phase_e;

    localparam int unsigned DEF_FAM_W  = 8;
    localparam int unsigned DEF_SER_W  = 48;
    localparam int unsigned DEF_CRC_W  = 8;
    localparam logic [7:0]  DEF_FAMILY = 8'h31;
    localparam logic [7:0]  DEF_POLY   = 8'h8C;  // x^8+x^5+x^4+1, reflected

endpackage

// File: rtl/aocrc_seq.sv
module aocrc_seq
    import aocrc_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 64,
    parameter int unsigned DATA_BITS  = 56,
    localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    output logic accept_o,
    output logic crc_en_o,
    output logic last_o,
    output logic done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t   st_d, st_q;
    phase_e phase;

    always_comb begin
        if (st_q.cnt < CNT_W'(DATA_BITS))       phase = PH_DATA;
        else if (st_q.cnt < CNT_W'(FRAME_BITS)) phase = PH_TAIL;
        else                                     phase = PH_FULL;

        accept_o = valid_i && !start_i && (phase != PH_FULL);
        crc_en_o = accept_o && (phase == PH_DATA);
        last_o   = accept_o && (st_q.cnt == CNT_W'(FRAME_BITS - 1));

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.cnt = '0;
        end else if (accept_o) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.done = last_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    assert_done_at_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.cnt == CNT_W'(FRAME_BITS));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAME_BITS));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cnt == '0) && !st_q.done);

endmodule

// File: rtl/aocrc_lfsr.sv
module aocrc_lfsr #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] POLY    = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] crc_o
);

    typedef struct packed {
        logic [W-1:0] crc;
    } lfsr_t;

    lfsr_t        st_d, st_q;
    logic         fb;
    logic [W-1:0] step;

    assign fb = din_i ^ st_q.crc[0];

    // Shift right; feedback enters the top bit and every tap named by POLY
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            assign step[i] = POLY[i] & fb;
        end else begin : g_mid
            assign step[i] = st_q.crc[i+1] ^ (POLY[i] & fb);
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_i)     st_d.crc = '0;
        else if (en_i) st_d.crc = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o = st_q.crc;

    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(st_q.crc));

endmodule

// File: rtl/aocrc_frame.sv
module aocrc_frame #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         din_i,
    output logic [N-1:0] nxt_o
);

    typedef struct packed {
        logic [N-1:0] sr;
    } frame_t;

    frame_t st_d, st_q;

    // New bits enter at the top, so after N shifts the first bit sits at bit 0
    always_comb begin
        st_d = st_q;
        if (en_i) st_d.sr = {din_i, st_q.sr[N-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nxt_o = st_d.sr;

endmodule

// File: rtl/addr_crc_check.sv
module addr_crc_check
    import aocrc_pkg::*;
#(
    parameter int unsigned       FAM_W       = DEF_FAM_W,
    parameter int unsigned       SER_W       = DEF_SER_W,
    parameter int unsigned       CRC_W       = DEF_CRC_W,
    parameter logic [FAM_W-1:0]  FAMILY_CODE = DEF_FAMILY,
    parameter logic [CRC_W-1:0]  CRC_POLY    = DEF_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bit_valid_i,
    input  logic              bit_data_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic [FAM_W-1:0]  family_o,
    output logic [SER_W-1:0]  serial_o,
    output logic              done_o,
    output logic              match_o,
    output logic              family_ok_o
);

    localparam int unsigned DATA_BITS  = FAM_W + SER_W;
    localparam int unsigned FRAME_BITS = DATA_BITS + CRC_W;

    typedef struct packed {
        logic [FAM_W-1:0] fam;
        logic [SER_W-1:0] ser;
        logic             match;
        logic             fok;
    } cap_t;

    logic                  accept, crc_en, last;
    logic [FRAME_BITS-1:0] frame_nxt;
    logic [CRC_W-1:0]      crc_q;
    logic [CRC_W-1:0]      rx_crc;
    cap_t                  cap_d, cap_q;

    aocrc_seq #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_BITS  (DATA_BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (bit_valid_i),
        .accept_o (accept),
        .crc_en_o (crc_en),
        .last_o   (last),
        .done_o   (done_o)
    );

    aocrc_lfsr #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .en_i  (crc_en),
        .din_i (bit_data_i),
        .crc_o (crc_q)
    );

    aocrc_frame #(
        .N (FRAME_BITS)
    ) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (accept),
        .din_i (bit_data_i),
        .nxt_o (frame_nxt)
    );

    assign rx_crc = frame_nxt[FRAME_BITS-1:DATA_BITS];

    always_comb begin
        cap_d = cap_q;
        if (start_i) begin
            cap_d.match = 1'b0;
            cap_d.fok   = 1'b0;
        end else if (last) begin
            cap_d.fam   = frame_nxt[FAM_W-1:0];
            cap_d.ser   = frame_nxt[DATA_BITS-1:FAM_W];
            cap_d.match = (rx_crc == crc_q);
            cap_d.fok   = (frame_nxt[FAM_W-1:0] == FAMILY_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign crc_o       = crc_q;
    assign family_o    = cap_q.fam;
    assign serial_o    = cap_q.ser;
    assign match_o     = cap_q.match;
    assign family_ok_o = cap_q.fok;

    assert_match_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_q.match) |-> done_o);

    assert_fok_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_q.fok) |-> done_o);

    assert_start_drops_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !match_o && !family_ok_o && (crc_o == '0));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(crc_o) && $stable(family_o) && $stable(serial_o));

endmodule

// File: tb/addr_crc_check_test.sv
module addr_crc_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_data_i = 1'b0;
    logic [7:0]  crc_o;
    logic [7:0]  family_o;
    logic [47:0] serial_o;
    logic        done_o, match_o, family_ok_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    addr_crc_check uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i),
        .crc_o(crc_o), .family_o(family_o), .serial_o(serial_o),
        .done_o(done_o), .match_o(match_o), .family_ok_o(family_ok_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bit-serial CRC per R2: feedback = bit ^ lsb, shift right, XOR 0x8C on feedback
    function automatic logic [7:0] model_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = d[i] ^ c[0];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] mk(input logic [7:0] fam, input logic [47:0] ser,
                                       input logic [7:0] corrupt);
        logic [55:0] d = {ser, fam};
        return {model_crc(d) ^ corrupt, d};
    endfunction

    // Drives the 64 bits LSB first; checks crc_o just before bit 57 (R2)
    task automatic send_frame(input logic [63:0] f, input bit gaps);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                bit_valid_i = 1'b0;
                bit_data_i  = ~f[i];
                @(negedge clk);
            end
            if (i == 56) chk("R2", "crc after 56 bits", 64'(crc_o), 64'(model_crc(f[55:0])));
            bit_valid_i = 1'b1;
            bit_data_i  = f[i];
        end
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_result(input string tag, input logic [63:0] f, input bit exp_match);
        chk("R4", {tag, " done"}, 64'(done_o), 64'd1);
        chk("R3", {tag, " family"}, 64'(family_o), 64'(f[7:0]));
        chk("R3", {tag, " serial"}, 64'(serial_o), 64'(f[55:8]));
        chk("R2", {tag, " final crc"}, 64'(crc_o), 64'(model_crc(f[55:0])));
        chk("R5", {tag, " match"}, 64'(match_o), 64'(exp_match));
        chk("R6", {tag, " family_ok"}, 64'(family_ok_o), 64'(f[7:0] == 8'h31));
        @(negedge clk);
        chk("R4", {tag, " done one cycle"}, 64'(done_o), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", "done", 64'(done_o), 0);
        chk("R1", "match", 64'(match_o), 0);
        chk("R1", "family_ok", 64'(family_ok_o), 0);
        chk("R1", "crc", 64'(crc_o), 0);
        chk("R1", "fields", {8'h0, serial_o, family_o}, 0);
    endtask

    task automatic t_good();
        logic [63:0] f = mk(8'h31, 48'h00A5_1234_BEEF, 8'h00);
        pulse_start();
        send_frame(f, 1'b0);
        check_result("good", f, 1'b1);
    endtask

    task automatic t_bad_crc_gaps();
        logic [63:0] f = mk(8'h31, 48'hC0DE_0000_7711, 8'h10);
        pulse_start();
        send_frame(f, 1'b1);   // R7: gaps inserted
        check_result("bad crc R5 R7", f, 1'b0);
    endtask

    task automatic t_known();
        logic [63:0] f = 64'hA200_0000_01B8_1C02;
        chk("R2", "model known vector", 64'(model_crc(f[55:0])), 64'hA2);
        pulse_start();
        send_frame(f, 1'b0);
        check_result("known R6", f, 1'b1);
    endtask

    task automatic t_abort();
        logic [63:0] f = mk(8'h31, 48'h1357_9BDF_2468, 8'h00);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_valid_i = 1'b1;
            bit_data_i  = ~f[i];
        end
        @(negedge clk);
        start_i = 1'b1;
        bit_valid_i = 1'b1;
        bit_data_i  = 1'b1;   // must be dropped (R8)
        @(negedge clk);
        start_i = 1'b0;
        bit_valid_i = 1'b0;
        chk("R8", "crc cleared", 64'(crc_o), 0);
        chk("R8", "match cleared", 64'(match_o), 0);
        chk("R8", "family_ok cleared", 64'(family_ok_o), 0);
        send_frame(f, 1'b0);
        check_result("after abort R8", f, 1'b1);
    endtask

    task automatic t_extra();
        logic [63:0] f = mk(8'h31, 48'hFFFF_0000_AAAA, 8'h00);
        logic        seen = 1'b0;
        pulse_start();
        send_frame(f, 1'b0);
        check_result("pre extra", f, 1'b1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
            bit_valid_i = 1'b1;
            bit_data_i  = i[0];
        end
        @(negedge clk);
        bit_valid_i = 1'b0;
        if (done_o) seen = 1'b1;
        @(negedge clk);
        if (done_o) seen = 1'b1;
        chk("R9", "no extra done", 64'(seen), 0);
        chk("R9", "family held", 64'(family_o), 64'(f[7:0]));
        chk("R9", "serial held", 64'(serial_o), 64'(f[55:8]));
        chk("R9", "crc held", 64'(crc_o), 64'(model_crc(f[55:0])));
        chk("R9", "match held", 64'(match_o), 1);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_bad_crc_gaps();
        t_known();
        t_good();
        t_abort();
        t_extra();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule